// File: doc/BRIEF.md
# Serial configuration frame parser

This block takes a configuration bitstream one bit per clock, most significant bit first, qualified by a bit-valid strobe. Clock cycles with the strobe low carry nothing and are skipped. The parser first waits for a run of at least four consecutive ones. It then reads a four-bit preamble that starts with the first zero after that run. The preamble decides one of three outcomes: a configuration frame follows, configuration is finished, or the stream is corrupt and the whole configuration must start again.

A configuration frame begins with a 19-bit header. The header holds a CRC enable bit, a 16-bit CRC field and a 2-bit compression code. An 11-bit row address follows. A standard frame (compression code 00) then carries a data field of `DW` bits. Every frame closes with a stop bit and two alignment bits. When the frame checks out, the parser issues one of two things:
- a single-cycle write of address and data to the configuration memory port, for a standard frame;
- a single-cycle reset, hold or set command with the address only, for a compressed frame.

CRC arithmetic is done by an external checker. That checker reads the captured CRC fields from this block and returns a failure flag.

The control is a six-state machine. The states are:
- HUNT: counts ones.
- PRE: reads the preamble.
- HDR: reads the header.
- ADDR: reads the address.
- DATA: reads the data field, standard frames only.
- TAIL: reads the stop and alignment bits.

The transitions are:
- HUNT→PRE: a zero after four or more ones.
- PRE→HDR: preamble 0010.
- PRE→HUNT: any other preamble.
- HDR→ADDR: 19 header bits received.
- ADDR→DATA: compression code 00.
- ADDR→TAIL: any other compression code.
- DATA→TAIL: `DW` data bits received.
- TAIL→HUNT: the third tail bit received.

Top module: `cfg_frame_parser`

## Requirements
- R1: After reset, wr_en, cmd_en, cfg_done, err_frame, err_pre and restart are all 0.
- R2: A frame is recognised only when at least four consecutive valid 1 bits come before the first 0 bit of the preamble. With three or fewer ones, that 0 is discarded and the parser keeps hunting.
- R3: A frame with preamble 0010 and compression code 00 gives a wr_en pulse exactly one clock long. The pulse is high in the cycle after the clock edge that accepts the last alignment bit. During the pulse, wr_addr holds the 11-bit address and wr_data holds the `DW` data bits, with the first received bit in the most significant position.
- R4: Compression code 01 (reset), 10 (hold) or 11 (set) gives a cmd_en pulse with the same timing as R3. During the pulse, cmd_op equals the code, wr_addr holds the address, and no data field is expected.
- R5: Preamble 0100 gives a one-cycle cfg_done pulse after its last preamble bit. No write or command follows.
- R6: Any preamble other than 0010 or 0100 gives a one-cycle err_pre pulse together with a restart pulse, and the parser returns to hunting.
- R7: A stop bit that is not 0, or alignment bits that are not 11, give err_frame with restart instead of a write or command.
- R8: An address of 1011 or above is rejected with err_frame and restart. Address 1010 is accepted.
- R9: When crc_fail is high in the cycle that carries the last alignment bit, the write or command is suppressed and only restart pulses.
- R10: Cycles with bit_vld low change no parser state, whatever bit_in holds.
- R11: hdr_crc_en and hdr_crc carry the header's CRC enable bit and 16-bit CRC field, in transmission order with the first bit most significant. They hold stable from the end of the header through the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial configuration bit |
| bit_vld | input | 1 | bit_in carries a valid bit this cycle |
| crc_fail | input | 1 | CRC mismatch flag from the external checker |
| wr_en | output | 1 | One-cycle write strobe for a standard frame |
| wr_addr | output | AW | Row address of the current frame |
| wr_data | output | DW | Data field of the last standard frame |
| cmd_en | output | 1 | One-cycle strobe for a compressed frame |
| cmd_op | output | 2 | Compression code: 01 reset, 10 hold, 11 set |
| cfg_done | output | 1 | One-cycle end-of-configuration pulse |
| err_frame | output | 1 | One-cycle pulse for a bad stop bit, bad alignment bits or an out-of-range address |
| err_pre | output | 1 | One-cycle pulse for an illegal preamble |
| restart | output | 1 | One-cycle pulse requesting a configuration restart |
| hdr_crc_en | output | 1 | Captured CRC enable bit |
| hdr_crc | output | 16 | Captured CRC field |

## Verification
Standard frames are sent with two different data patterns and addresses. This shows that the data bits land in order and that a write stays separate from a command. All three compressed codes are sent, to show that each code maps to its own cmd_op with no write. Frames with idle gaps are mixed in, with bit_in toggling while bit_vld is low. These must give the same result as frames without gaps.

The corner patterns are:
- a short run of ones;
- the end preamble and an illegal preamble;
- a bad stop bit and bad alignment bits;
- addresses 1010 and 1011;
- a CRC failure.

Each of these shows whether the parser rejects exactly the malformed case and returns to hunting.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PRE,
        ST_HDR,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } cfgp_state_e;

    typedef enum logic [1:0] {
        CMP_STD  = 2'b00,
        CMP_RST  = 2'b01,
        CMP_HOLD = 2'b10,
        CMP_SET  = 2'b11
    } cfgp_comp_e;

    localparam logic [3:0] PRE_CFG = 4'b0010;
    localparam logic [3:0] PRE_END = 4'b0100;
    localparam int PRE_BITS  = 4;
    localparam int HDR_BITS  = 19;
    localparam int TAIL_BITS = 3;
    localparam int MIN_ONES  = 4;
    localparam int CRC_BITS  = 16;
endpackage

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/cfgp_bitcnt.sv
module cfgp_bitcnt #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int DW         = 546,
    parameter int AW         = 11,
    parameter int ADDR_LIMIT = 1011,
    parameter int CW         = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    input  logic                  bit_vld,
    input  logic                  crc_fail,
    input  logic [CW-1:0]         cnt,
    input  logic [PRE_BITS-2:0]   pre_q,
    input  logic [HDR_BITS-1:0]   hdr_q,
    input  logic [AW-1:0]         addr_q,
    input  logic [TAIL_BITS-2:0]  tail_q,
    output logic                  cnt_clr,
    output logic                  cnt_inc,
    output logic                  en_pre,
    output logic                  en_hdr,
    output logic                  en_addr,
    output logic                  en_data,
    output logic                  en_tail,
    output logic                  wr_en,
    output logic                  cmd_en,
    output logic                  cfg_done,
    output logic                  err_frame,
    output logic                  err_pre,
    output logic                  restart
);
    cfgp_state_e state_q, state_d;
    logic [2:0]          ones_q;
    logic [CW-1:0]       last_cnt;
    logic                field_last;
    logic [PRE_BITS-1:0] pre_full;
    logic [TAIL_BITS-1:0] tail_full;
    logic                tail_bad;

    assign pre_full  = {pre_q, bit_in};
    assign tail_full = {tail_q, bit_in};
    assign tail_bad  = tail_full[2] || (tail_full[1:0] != 2'b11) ||
                       (32'(addr_q) >= ADDR_LIMIT);

    // index of the last bit of the field being received
    always_comb begin
        unique case (state_q)
            ST_PRE:  last_cnt = CW'(PRE_BITS - 2);
            ST_HDR:  last_cnt = CW'(HDR_BITS - 1);
            ST_ADDR: last_cnt = CW'(AW - 1);
            ST_DATA: last_cnt = CW'(DW - 1);
            ST_TAIL: last_cnt = CW'(TAIL_BITS - 1);
            default: last_cnt = '0;
        endcase
    end

    assign field_last = bit_vld && (state_q != ST_HUNT) && (cnt == last_cnt);
    assign cnt_clr    = field_last || (state_q == ST_HUNT);
    assign cnt_inc    = bit_vld && (state_q != ST_HUNT) && !field_last;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (bit_vld && !bit_in && ones_q >= 3'(MIN_ONES))
                         state_d = ST_PRE;
            ST_PRE:  if (field_last)
                         state_d = (pre_full == PRE_CFG) ? ST_HDR : ST_HUNT;
            ST_HDR:  if (field_last) state_d = ST_ADDR;
            ST_ADDR: if (field_last)
                         state_d = (hdr_q[1:0] == CMP_STD) ? ST_DATA : ST_TAIL;
            ST_DATA: if (field_last) state_d = ST_TAIL;
            ST_TAIL: if (field_last) state_d = ST_HUNT;
            default: state_d = ST_HUNT;
        endcase
    end

    assign en_pre  = bit_vld && (((state_q == ST_HUNT) && (state_d == ST_PRE)) ||
                                 (state_q == ST_PRE));
    assign en_hdr  = bit_vld && (state_q == ST_HDR);
    assign en_addr = bit_vld && (state_q == ST_ADDR);
    assign en_data = bit_vld && (state_q == ST_DATA);
    assign en_tail = bit_vld && (state_q == ST_TAIL);

    // state register with leading-ones counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            ones_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_HUNT)
                ones_q <= '0;
            else if (bit_vld)
                ones_q <= !bit_in ? 3'd0 :
                          (ones_q < 3'(MIN_ONES)) ? ones_q + 3'd1 : ones_q;
        end
    end

    // registered single-cycle outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            cmd_en    <= 1'b0;
            cfg_done  <= 1'b0;
            err_frame <= 1'b0;
            err_pre   <= 1'b0;
            restart   <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            cmd_en    <= 1'b0;
            cfg_done  <= 1'b0;
            err_frame <= 1'b0;
            err_pre   <= 1'b0;
            restart   <= 1'b0;
            if (field_last) begin
                unique case (state_q)
                    ST_PRE: begin
                        if (pre_full == PRE_END) begin
                            cfg_done <= 1'b1;
                        end else if (pre_full != PRE_CFG) begin
                            err_pre <= 1'b1;
                            restart <= 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        if (tail_bad) begin
                            err_frame <= 1'b1;
                            restart   <= 1'b1;
                        end else if (crc_fail) begin
                            restart <= 1'b1;
                        end else if (hdr_q[1:0] == CMP_STD) begin
                            wr_en <= 1'b1;
                        end else begin
                            cmd_en <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    a_r8_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || cmd_en) |-> (32'(addr_q) < ADDR_LIMIT));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(state_q));
    a_r11_hdr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA || state_q == ST_TAIL) |=> $stable(hdr_q));
endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
    import cfgp_pkg::*;
#(
    parameter int DW         = 546,
    parameter int AW         = 11,
    parameter int ADDR_LIMIT = 1011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic          crc_fail,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          cmd_en,
    output logic [1:0]    cmd_op,
    output logic          cfg_done,
    output logic          err_frame,
    output logic          err_pre,
    output logic          restart,
    output logic          hdr_crc_en,
    output logic [15:0]   hdr_crc
);
    localparam int CW = $clog2(DW + 1);

    logic [CW-1:0]          cnt;
    logic                   cnt_clr, cnt_inc;
    logic                   en_pre, en_hdr, en_addr, en_data, en_tail;
    logic [PRE_BITS-2:0]    pre_q;
    logic [HDR_BITS-1:0]    hdr_q;
    logic [TAIL_BITS-2:0]   tail_q;

    cfgp_bitcnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(cnt)
    );

    cfgp_shreg #(.W(PRE_BITS-1)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en_pre), .din(bit_in), .q(pre_q)
    );
    cfgp_shreg #(.W(HDR_BITS)) u_hdr (
        .clk(clk), .rst_n(rst_n), .en(en_hdr), .din(bit_in), .q(hdr_q)
    );
    cfgp_shreg #(.W(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .en(en_addr), .din(bit_in), .q(wr_addr)
    );
    cfgp_shreg #(.W(DW)) u_data (
        .clk(clk), .rst_n(rst_n), .en(en_data), .din(bit_in), .q(wr_data)
    );
    cfgp_shreg #(.W(TAIL_BITS-1)) u_tail (
        .clk(clk), .rst_n(rst_n), .en(en_tail), .din(bit_in), .q(tail_q)
    );

    cfgp_ctrl #(.DW(DW), .AW(AW), .ADDR_LIMIT(ADDR_LIMIT), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .crc_fail(crc_fail), .cnt(cnt), .pre_q(pre_q), .hdr_q(hdr_q),
        .addr_q(wr_addr), .tail_q(tail_q), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .en_pre(en_pre), .en_hdr(en_hdr), .en_addr(en_addr), .en_data(en_data),
        .en_tail(en_tail), .wr_en(wr_en), .cmd_en(cmd_en), .cfg_done(cfg_done),
        .err_frame(err_frame), .err_pre(err_pre), .restart(restart)
    );

    assign hdr_crc_en = hdr_q[HDR_BITS-1];
    assign hdr_crc    = hdr_q[HDR_BITS-2 -: CRC_BITS];
    assign cmd_op     = hdr_q[1:0];

    a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, cmd_en, cfg_done, err_frame, err_pre}));
    a_r6_err_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pre || err_frame) |-> restart);
endmodule

// File: tb/sim_cfg_frame_parser.sv
`timescale 1ns/1ps
module sim_cfg_frame_parser;
    localparam int DW = 546;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b1;
    logic          bit_vld = 1'b0;
    logic          crc_fail = 1'b0;
    logic          wr_en, cmd_en, cfg_done, err_frame, err_pre, restart;
    logic [10:0]   wr_addr;
    logic [DW-1:0] wr_data;
    logic [1:0]    cmd_op;
    logic          hdr_crc_en;
    logic [15:0]   hdr_crc;

    int total = 0;
    int bad = 0;
    int n_wr = 0, n_cmd = 0, n_done = 0, n_ferr = 0, n_perr = 0, n_rst = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cfg_frame_parser #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .crc_fail(crc_fail), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_en(cmd_en), .cmd_op(cmd_op), .cfg_done(cfg_done),
        .err_frame(err_frame), .err_pre(err_pre), .restart(restart),
        .hdr_crc_en(hdr_crc_en), .hdr_crc(hdr_crc)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            n_wr   <= n_wr + int'(wr_en);
            n_cmd  <= n_cmd + int'(cmd_en);
            n_done <= n_done + int'(cfg_done);
            n_ferr <= n_ferr + int'(err_frame);
            n_perr <= n_perr + int'(err_pre);
            n_rst  <= n_rst + int'(restart);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_data(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] make_data(input int seed);
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++)
            d[i] = (((i * 7 + seed) % 5) < 2);
        return d;
    endfunction

    task automatic send_bit(input logic b, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in = ~bit_in;
            @(posedge clk);
        end
        @(negedge clk);
        bit_in = b;
        bit_vld = 1'b1;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            crc_fail = 1'b0;
        end
    endtask

    // sends a whole frame; returns at the negedge after its last bit
    task automatic send_frame(input int ones, input logic [3:0] pre,
                              input logic crcen, input logic [15:0] crc,
                              input logic [1:0] comp, input logic [10:0] addr,
                              input logic [DW-1:0] data, input logic stop,
                              input logic [1:0] align, input logic crcbad,
                              input int gap);
        crc_fail = crcbad;
        for (int i = 0; i < ones; i++) send_bit(1'b1, gap);
        for (int i = 3; i >= 0; i--) send_bit(pre[i], gap);
        if (pre == 4'b0010) begin
            send_bit(crcen, gap);
            for (int i = 15; i >= 0; i--) send_bit(crc[i], gap);
            for (int i = 1; i >= 0; i--) send_bit(comp[i], gap);
            for (int i = 10; i >= 0; i--) send_bit(addr[i], gap);
            if (comp == 2'b00)
                for (int i = DW - 1; i >= 0; i--) send_bit(data[i], gap);
            send_bit(stop, gap);
            send_bit(align[1], gap);
            send_bit(align[0], gap);
        end
        @(negedge clk);
        bit_vld = 1'b0;
        crc_fail = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 wr_en", 64'(wr_en), 0);
        chk("R1 cmd_en", 64'(cmd_en), 0);
        chk("R1 cfg_done", 64'(cfg_done), 0);
        chk("R1 err_frame", 64'(err_frame), 0);
        chk("R1 err_pre", 64'(err_pre), 0);
        chk("R1 restart", 64'(restart), 0);
    endtask

    task automatic t_standard;
        logic [DW-1:0] d1, d2;
        int w0;
        d1 = make_data(3);
        d2 = make_data(11);
        w0 = n_wr;
        send_frame(6, 4'b0010, 1'b0, 16'haaaa, 2'b00, 11'd5, d1, 1'b0, 2'b11, 1'b0, 0);
        chk("R3 wr_en pulse", 64'(wr_en), 1);
        chk("R3 wr_addr", 64'(wr_addr), 5);
        chk_data("R3 wr_data", wr_data, d1);
        @(negedge clk);
        chk("R3 wr_en one cycle", 64'(wr_en), 0);
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b00, 11'd1010, d2, 1'b0, 2'b11, 1'b0, 0);
        idle(3);
        chk("R8 addr 1010 accepted", 64'(n_wr - w0), 2);
        chk("R8 addr 1010 value", 64'(wr_addr), 1010);
        chk_data("R3 second pattern", wr_data, d2);
        chk("R3 no cmd", 64'(n_cmd), 0);
    endtask

    task automatic t_compressed;
        logic [1:0] codes [3];
        int w0, c0;
        codes[0] = 2'b01;
        codes[1] = 2'b10;
        codes[2] = 2'b11;
        w0 = n_wr;
        for (int k = 0; k < 3; k++) begin
            c0 = n_cmd;
            send_frame(5, 4'b0010, 1'b0, 16'haaaa, codes[k], 11'(100 + k), '0,
                       1'b0, 2'b11, 1'b0, 0);
            chk("R4 cmd_en pulse", 64'(cmd_en), 1);
            chk("R4 cmd_op", 64'(cmd_op), 64'(codes[k]));
            chk("R4 cmd addr", 64'(wr_addr), 64'(100 + k));
            idle(2);
            chk("R4 one cmd", 64'(n_cmd - c0), 1);
        end
        chk("R4 no write", 64'(n_wr - w0), 0);
    endtask

    task automatic t_gaps;
        logic [DW-1:0] d;
        int w0;
        d = make_data(29);
        w0 = n_wr;
        send_frame(4, 4'b0010, 1'b1, 16'h1234, 2'b00, 11'd777, d, 1'b0, 2'b11, 1'b0, 1);
        idle(3);
        chk("R10 gapped write", 64'(n_wr - w0), 1);
        chk("R10 gapped addr", 64'(wr_addr), 777);
        chk_data("R10 gapped data", wr_data, d);
        chk("R11 crc enable", 64'(hdr_crc_en), 1);
        chk("R11 crc field", 64'(hdr_crc), 64'h1234);
    endtask

    task automatic t_few_ones;
        int w0, e0, p0, r0;
        w0 = n_wr; e0 = n_ferr; p0 = n_perr; r0 = n_rst;
        send_frame(3, 4'b0010, 1'b0, 16'haaaa, 2'b00, 11'd0, '0, 1'b0, 2'b11, 1'b0, 0);
        idle(3);
        chk("R2 short run no write", 64'(n_wr - w0), 0);
        chk("R2 short run no error", 64'((n_ferr - e0) + (n_perr - p0) + (n_rst - r0)), 0);
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b10, 11'd9, '0, 1'b0, 2'b11, 1'b0, 0);
        chk("R2 recovers", 64'(cmd_en), 1);
    endtask

    task automatic t_preambles;
        int w0, d0, p0, r0;
        w0 = n_wr; d0 = n_done;
        send_frame(4, 4'b0100, 1'b0, 16'h0, 2'b00, 11'd0, '0, 1'b0, 2'b11, 1'b0, 0);
        chk("R5 cfg_done pulse", 64'(cfg_done), 1);
        idle(3);
        chk("R5 single done", 64'(n_done - d0), 1);
        chk("R5 no write", 64'(n_wr - w0), 0);
        p0 = n_perr; r0 = n_rst;
        send_frame(4, 4'b0110, 1'b0, 16'h0, 2'b00, 11'd0, '0, 1'b0, 2'b11, 1'b0, 0);
        chk("R6 err_pre", 64'(err_pre), 1);
        chk("R6 restart", 64'(restart), 1);
        idle(3);
        chk("R6 single restart", 64'(n_rst - r0), 1);
        chk("R6 single err_pre", 64'(n_perr - p0), 1);
    endtask

    task automatic t_bad_tail;
        int w0, c0, e0, r0;
        w0 = n_wr; c0 = n_cmd; e0 = n_ferr; r0 = n_rst;
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b00, 11'd8, make_data(1), 1'b1, 2'b11, 1'b0, 0);
        chk("R7 stop bit err", 64'(err_frame), 1);
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b01, 11'd8, '0, 1'b0, 2'b10, 1'b0, 0);
        chk("R7 align err", 64'(err_frame), 1);
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b00, 11'd1011, make_data(2), 1'b0, 2'b11, 1'b0, 0);
        chk("R8 addr 1011 err", 64'(err_frame), 1);
        send_frame(4, 4'b0010, 1'b0, 16'haaaa, 2'b11, 11'd2047, '0, 1'b0, 2'b11, 1'b0, 0);
        chk("R8 addr 2047 err", 64'(err_frame), 1);
        idle(3);
        chk("R7 no write or cmd", 64'((n_wr - w0) + (n_cmd - c0)), 0);
        chk("R7 err count", 64'(n_ferr - e0), 4);
        chk("R8 restart count", 64'(n_rst - r0), 4);
    endtask

    task automatic t_crc;
        int w0, r0, e0;
        w0 = n_wr; r0 = n_rst; e0 = n_ferr;
        send_frame(4, 4'b0010, 1'b1, 16'hbeef, 2'b00, 11'd20, make_data(5), 1'b0, 2'b11, 1'b1, 0);
        chk("R9 restart", 64'(restart), 1);
        idle(3);
        chk("R9 no write", 64'(n_wr - w0), 0);
        chk("R9 no frame err", 64'(n_ferr - e0), 0);
        chk("R9 one restart", 64'(n_rst - r0), 1);
        chk("R11 crc field held", 64'(hdr_crc), 64'hbeef);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standard();
        t_compressed();
        t_gaps();
        t_few_ones();
        t_preambles();
        t_bad_tail();
        t_crc();
        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule